// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block makes the serial clock for an I2C bus controller from a faster input clock. A programmable prescaler divides the input clock into a module clock. Two phase registers then give the length of the low and the high half of each serial clock period, both counted in module-clock ticks.

Each phase also gets a fixed padding of 5, 6 or 7 module ticks. The size of that padding is picked from the prescaler value. Software loads the prescaler and the two phase lengths through a small write port, then sets the run bit. While the run bit is clear the block is held idle and the serial clock line stays released (high).

Values written while the clock runs are taken at the start of the next low phase. A period that is already under way is therefore finished with the values it started with. The prescaler should be chosen so that the module clock lands between 7 MHz and 12 MHz. Clock stretching and multi-master synchronisation are not part of this block.

Top module: `scl_clkgen`

## Requirements
- R1: After `rst_n` is released, and for as long as the run bit is 0, `scl_o` is 1 and `phase_tick_o` is 0.
- R2: The module clock ticks once every P+1 input clock cycles, where P is the prescaler register value. Every phase length therefore scales by P+1, and the serial clock never changes between module ticks.
- R3: The low phase lasts (L + pad) * (P+1) input clock cycles, where L is the low-phase register value.
- R4: The high phase lasts (H + pad) * (P+1) input clock cycles, where H is the high-phase register value.
- R5: The padding is 7 when P = 0, 6 when P = 1, and 5 when P is 2 or more.
- R6: Writes go through `wr_sel`:
  - select 1 is the prescaler, select 2 the low phase, select 3 the high phase, each 16 bits wide;
  - select 0 is control, where only bit 0 (run) has meaning and all other bits are ignored.
- R7: The first input clock edge after the write edge that sets run begins a low phase. `scl_o` is 1 in the cycle following the write edge and 0 one cycle later.
- R8: `phase_tick_o` is 1 for exactly those cycles in which `scl_o` holds a value different from the previous cycle.
- R9: Prescaler, low and high values written while running first apply at the next low-phase start. The phase in progress keeps its length.
- R10: Clearing run drives `scl_o` high on the input clock edge after the write edge, whatever phase was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 prescaler, 2 low phase, 3 high phase |
| wr_data | input | 16 | Write data |
| scl_o | output | 1 | Serial clock level (1 = released) |
| phase_tick_o | output | 1 | One-cycle pulse whenever `scl_o` changes |

## Verification
Every result in this block can be counted from a write edge:
- the run bit acts one edge after its write edge, so a start or a stop shows on `scl_o` in the second cycle after that write edge;
- a phase length is an exact product of (count + pad) and (P+1).

The bench samples on the falling clock edge, midway between register updates. It reads `scl_o` in the cycle just after a write and again one cycle later, so the two-cycle latency of a start or a stop is pinned exactly. A monitor measures each complete low and high run in whole cycles and compares it with the arithmetic product. For the deferred update, the bench writes new values during a high phase and checks that this high phase keeps its old length while the next two phases use the new one.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL     = 2'd0,
      SEL_PRESCALE = 2'd1,
      SEL_LOW      = 2'd2,
      SEL_HIGH     = 2'd3
   } sel_e;

   localparam int unsigned PAD_W = 3;

   // Fixed padding added to each phase, picked from the prescaler value.
   function automatic logic [PAD_W-1:0] pad_of(input logic psc_is_zero,
                                               input logic psc_is_one);
      if (psc_is_zero)     return 3'd7;
      else if (psc_is_one) return 3'd6;
      else                 return 3'd5;
   endfunction

endpackage

// File: rtl/scl_regs.sv
module scl_regs #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              run,
   output logic [DATA_W-1:0] prescale,
   output logic [DATA_W-1:0] low_cnt,
   output logic [DATA_W-1:0] high_cnt
);
   import scl_gen_pkg::*;

   localparam int unsigned NUM_DIV = 3;

   logic [DATA_W-1:0] div_q [NUM_DIV];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            run <= 1'b0;
      else if (wr_en && wr_sel == SEL_CTRL)  run <= wr_data[0];
   end

   for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               div_q[g] <= '0;
         else if (wr_en && wr_sel == 2'(g + 1))    div_q[g] <= wr_data;
      end
   end

   assign prescale = div_q[0];
   assign low_cnt  = div_q[1];
   assign high_cnt = div_q[2];
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
   parameter int unsigned DATA_W      = 16,
   parameter bit          PRESCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [DATA_W-1:0] div,
   output logic              mod_tick
);
   if (PRESCALE_EN) begin : g_div
      logic [DATA_W-1:0] cnt_q;
      logic              wrap;

      assign wrap     = (cnt_q == div);
      assign mod_tick = active && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt_q <= '0;
         else if (!active || wrap) cnt_q <= '0;
         else                      cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_bypass
      logic unused_div;
      assign unused_div = ^div;
      assign mod_tick   = active;
   end
endmodule

// File: rtl/scl_phase.sv
module scl_phase #(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned CNT_W = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              mod_tick,
   input  logic [DATA_W-1:0] psc_in,
   input  logic [DATA_W-1:0] low_in,
   input  logic [DATA_W-1:0] high_in,
   output logic [DATA_W-1:0] psc_act,
   output logic              active,
   output logic              scl,
   output logic              phase_tick
);
   import scl_gen_pkg::*;

   logic [CNT_W-1:0]  cnt_q, cnt_nxt;
   logic [DATA_W-1:0] high_s;
   logic [PAD_W-1:0]  pad_s, pad_in;
   logic              scl_nxt, act_nxt, latch;

   assign pad_in = pad_of(psc_in == '0, psc_in == DATA_W'(1));

   always_comb begin
      scl_nxt = scl;
      cnt_nxt = cnt_q;
      act_nxt = active;
      latch   = 1'b0;
      if (!run) begin
         scl_nxt = 1'b1;
         cnt_nxt = '0;
         act_nxt = 1'b0;
      end else if (!active || (mod_tick && cnt_q == '0 && scl)) begin
         latch   = 1'b1;
         scl_nxt = 1'b0;
         act_nxt = 1'b1;
         cnt_nxt = CNT_W'(low_in) + CNT_W'(pad_in) - CNT_W'(1);
      end else if (mod_tick) begin
         if (cnt_q == '0) begin
            scl_nxt = 1'b1;
            cnt_nxt = CNT_W'(high_s) + CNT_W'(pad_s) - CNT_W'(1);
         end else begin
            cnt_nxt = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         scl        <= 1'b1;
         active     <= 1'b0;
         phase_tick <= 1'b0;
      end else begin
         cnt_q      <= cnt_nxt;
         scl        <= scl_nxt;
         active     <= act_nxt;
         phase_tick <= (scl_nxt != scl);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         high_s  <= '0;
         psc_act <= '0;
         pad_s   <= 3'd7;
      end else if (latch) begin
         high_s  <= high_in;
         psc_act <= psc_in;
         pad_s   <= pad_in;
      end
   end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
   parameter int unsigned DATA_W      = 16,
   parameter bit          PRESCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              scl_o,
   output logic              phase_tick_o
);
   if (DATA_W < 3 || DATA_W > 31) begin : g_bad_width
      $error("scl_clkgen: DATA_W must lie in 3..31");
   end

   logic              run_q, active, mod_tick;
   logic [DATA_W-1:0] psc_reg, low_reg, high_reg, psc_act;

   scl_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .run      (run_q),
      .prescale (psc_reg),
      .low_cnt  (low_reg),
      .high_cnt (high_reg)
   );

   scl_prescale #(.DATA_W(DATA_W), .PRESCALE_EN(PRESCALE_EN)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .div      (psc_act),
      .mod_tick (mod_tick)
   );

   scl_phase #(.DATA_W(DATA_W)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q),
      .mod_tick   (mod_tick),
      .psc_in     (psc_reg),
      .low_in     (low_reg),
      .high_in    (high_reg),
      .psc_act    (psc_act),
      .active     (active),
      .scl        (scl_o),
      .phase_tick (phase_tick_o)
   );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic active,
   input logic mod_tick,
   input logic scl,
   input logic phase_tick
);
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> scl); // R1

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && $past(active) && !$past(mod_tick)) |-> $stable(scl)); // R2

   AST_TICK_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (scl != $past(scl)) |-> phase_tick); // R8

   AST_TICK_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_tick |-> (scl != $past(scl))); // R8
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run_q),
   .active     (active),
   .mod_tick   (mod_tick),
   .scl        (scl_o),
   .phase_tick (phase_tick_o)
);

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        scl, tick;

   int checks = 0, errors = 0;
   logic prev = 1'b1;
   int cur = 0, last_lo = 0, last_hi = 0, nphase = 0;

   always #2.5 clk = ~clk;

   scl_clkgen i_scl_clkgen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .scl_o(scl), .phase_tick_o(tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Run-length monitor with phase tick check (R8)
   always @(negedge clk) if (rst_n) begin
      if (scl !== prev) begin
         chk(tick === 1'b1, "R8 tick on change", int'(tick), 1);
         if (prev == 1'b0) last_lo = cur; else last_hi = cur;
         cur = 1;
         nphase++;
         prev = scl;
      end else begin
         cur++;
         if (tick !== 1'b0) chk(1'b0, "R8 tick without change", int'(tick), 0);
      end
   end

   function automatic int pad(input int p);
      return (p == 0) ? 7 : (p == 1) ? 6 : 5;
   endfunction

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_ph(input int n);
      while (nphase < n) @(posedge clk);
      @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk(scl === 1'b1 && tick === 1'b0, "R1 reset state", int'(scl), 1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(scl === 1'b1 && tick === 1'b0, "R1 idle after reset", int'(scl), 1);

      // R6: control bits other than bit 0 do nothing
      wr(2'd0, 16'hFFFE);
      repeat (20) @(negedge clk);
      chk(scl === 1'b1 && nphase == 0, "R6 ctrl upper bits ignored", nphase, 0);

      // R7: start timing
      wr(2'd0, 16'h0001);
      chk(scl === 1'b1, "R7 still high after write edge", int'(scl), 1);
      @(negedge clk);
      chk(scl === 1'b0 && tick === 1'b1, "R7 low phase begins", int'(scl), 0);
      wr(2'd0, 16'h0000);
      repeat (3) @(negedge clk);

      // Sweep: R2 R3 R4 R5 R6
      for (int p = 0; p < 4; p++) begin
         for (int li = 0; li < 3; li++) begin
            for (int hi = 0; hi < 2; hi++) begin
               int l, h, elo, ehi;
               l = (li == 2) ? 5 : li;
               h = hi * 3;
               elo = (l + pad(p)) * (p + 1);
               ehi = (h + pad(p)) * (p + 1);
               wr(2'd1, 16'(p)); wr(2'd2, 16'(l)); wr(2'd3, 16'(h));
               base = nphase;
               wr(2'd0, 16'h0001);
               wait_ph(base + 3);
               chk(last_lo == elo, "R3 R5 low length", last_lo, elo);
               chk(last_hi == ehi, "R4 R5 high length", last_hi, ehi);
               wait_ph(base + 5);
               chk(last_lo == elo, "R2 R3 second low", last_lo, elo);
               chk(last_hi == ehi, "R2 R4 second high", last_hi, ehi);
               wr(2'd0, 16'h0000);
               repeat (3) @(negedge clk);
            end
         end
      end

      // R10: stop in mid low phase
      wr(2'd1, 16'd0); wr(2'd2, 16'd4); wr(2'd3, 16'd4);
      wr(2'd0, 16'h0001);
      repeat (4) @(negedge clk);
      chk(scl === 1'b0, "R10 low before stop", int'(scl), 0);
      wr(2'd0, 16'h0000);
      @(negedge clk);
      chk(scl === 1'b1, "R10 released after stop", int'(scl), 1);
      repeat (30) @(negedge clk);
      chk(scl === 1'b1, "R1 stays high while stopped", int'(scl), 1);

      // R9: deferred update
      wr(2'd2, 16'd2); wr(2'd3, 16'd3);
      base = nphase;
      wr(2'd0, 16'h0001);
      wait_ph(base + 2);
      chk(scl === 1'b1, "R9 in high phase", int'(scl), 1);
      wr(2'd2, 16'd10); wr(2'd3, 16'd10);
      wait_ph(base + 3);
      chk(last_hi == 10, "R9 current high keeps old length", last_hi, 10);
      wait_ph(base + 5);
      chk(last_lo == 17, "R9 new low applied", last_lo, 17);
      chk(last_hi == 17, "R9 new high applied", last_hi, 17);
      wr(2'd0, 16'h0000);
      repeat (3) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule